// File: doc/BRIEF.md
# Quadrature Encoder Emulator

This block turns a 12-bit absolute shaft angle, produced elsewhere by a tracking loop, into the signals of an incremental encoder. It drives two quadrature phases, a once-per-revolution index marker and a rotation direction flag. Downstream logic written for an optical encoder can then count pulses as before.

An internal update strobe is derived from the block clock by a fixed divider, two by default. The angle is taken in only on that strobe. The tracking loop that feeds the angle is expected to move it by at most one LSB per update. The two lowest angle bits select the quadrature state, so a full 12-bit revolution yields 1024 cycles on each phase. The index marker is high for the one quadrature state at angle zero. Every output comes from a flop, so none of them can glitch.

Top module: `qenc_emulator`

## Requirements
- R1: While reset is high, and after it, the outputs show angle zero: phase_a=1, phase_b=0, index=1, dir_up=1. Reset is synchronous and active high.
- R2: The angle is sampled only on the update strobe. The strobe fires on every UPD_DIV-th rising clock edge after reset is released, the first being edge number UPD_DIV. A value that is present only between strobes has no effect on any output.
- R3: For a sampled angle, phase_a equals NOT bit 1 and phase_b equals bit 1 XOR bit 0. Counting up through the low bits 00, 01, 10, 11 gives (a,b) = 10, 11, 01, 00, so phase_a leads phase_b. One revolution of 4096 LSB produces 1024 rising edges on phase_a.
- R4: index is high exactly when the sampled angle is zero. At that point phase_a=1 and phase_b=0, which is one quarter of a phase_a cycle.
- R5: dir_up becomes 1 after a sampled step of +1 LSB, including 4095 to 0. It becomes 0 after a step of -1 LSB, including 0 to 4095. It can therefore change on a reversal at the same update as the phases.
- R6: dir_up keeps its value when the sampled angle does not change.
- R7: All outputs change only on the clock edge that carries the update strobe. They are registered, and at most one of phase_a and phase_b changes per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| angle_i | input | ANG_W | Tracked absolute angle |
| phase_a | output | 1 | Quadrature phase A |
| phase_b | output | 1 | Quadrature phase B |
| index | output | 1 | Once-per-revolution marker |
| dir_up | output | 1 | High while the angle is increasing |

## Verification
The assertions assume that the angle seen at two consecutive strobes differs by at most one LSB, modulo a revolution. Only under that assumption does the rule of one phase change per update hold. The stimulus holds each angle until a strobe edge and steps it by -1, 0 or +1, including both wraps through zero. The single larger jump is a pulse shorter than a strobe interval, placed between strobes, and a correct design never samples it.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef struct packed {
    logic a;
    logic b;
    logic idx;
  } qenc_pins_t;

  // Map the two low angle bits and a zero flag to the pin levels
  function automatic qenc_pins_t qenc_encode(input logic [1:0] lsb, input logic at_zero);
    qenc_pins_t p;
    p.a   = ~lsb[1];
    p.b   = lsb[1] ^ lsb[0];
    p.idx = at_zero;
    return p;
  endfunction

endpackage

// File: rtl/qenc_tick.sv
module qenc_tick #(
  parameter int UPD_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  generate
    if (UPD_DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(UPD_DIV);
      localparam logic [CW-1:0] LAST = CW'(UPD_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);

      // R2: strobes are never back to back when dividing
      a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/qenc_track.sv
module qenc_track #(
  parameter int ANG_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [ANG_W-1:0] angle_i,
  output logic             dir_o
);
  localparam logic [ANG_W-1:0] ONE = ANG_W'(1);

  logic [ANG_W-1:0] pos_q;
  logic             dir_q;
  logic             step_up, step_dn;

  assign step_up = (angle_i == pos_q + ONE);
  assign step_dn = (angle_i == pos_q - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      dir_q <= 1'b1;
    end else if (tick_i) begin
      pos_q <= angle_i;
      if (step_up)      dir_q <= 1'b1;
      else if (step_dn) dir_q <= 1'b0;
    end
  end

  assign dir_o = dir_q;

  // R5: a sampled upward step leaves the flag high
  a_r5_dir_up: assert property (@(posedge clk) disable iff (rst)
    (tick_i && angle_i == pos_q + ONE) |=> dir_o);
  // R5: a sampled downward step leaves the flag low
  a_r5_dir_down: assert property (@(posedge clk) disable iff (rst)
    (tick_i && angle_i == pos_q - ONE) |=> !dir_o);
  // R6: an unchanged angle keeps the flag
  a_r6_dir_hold: assert property (@(posedge clk) disable iff (rst)
    (tick_i && angle_i == pos_q) |=> $stable(dir_o));
endmodule

// File: rtl/qenc_pins.sv
module qenc_pins #(
  parameter int ANG_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [ANG_W-1:0] angle_i,
  output qenc_pkg::qenc_pins_t pins_o
);
  import qenc_pkg::*;

  qenc_pins_t pins_q;
  qenc_pins_t pins_d;

  assign pins_d = qenc_encode(angle_i[1:0], angle_i == '0);

  always_ff @(posedge clk) begin
    if (rst)         pins_q <= qenc_encode(2'b00, 1'b1);
    else if (tick_i) pins_q <= pins_d;
  end

  assign pins_o = pins_q;

  // R4: the marker only appears in the A-high, B-low quarter
  a_r4_index_quarter: assert property (@(posedge clk) disable iff (rst)
    pins_o.idx |-> (pins_o.a && !pins_o.b));
endmodule

// File: rtl/qenc_emulator.sv
module qenc_emulator #(
  parameter int ANG_W   = 12,
  parameter int UPD_DIV = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ANG_W-1:0] angle_i,
  output logic             phase_a,
  output logic             phase_b,
  output logic             index,
  output logic             dir_up
);
  import qenc_pkg::*;

  logic       tick;
  qenc_pins_t pins;

  qenc_tick #(.UPD_DIV(UPD_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  qenc_track #(.ANG_W(ANG_W)) u_track (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .angle_i (angle_i),
    .dir_o   (dir_up)
  );

  qenc_pins #(.ANG_W(ANG_W)) u_pins (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .angle_i (angle_i),
    .pins_o  (pins)
  );

  assign phase_a = pins.a;
  assign phase_b = pins.b;
  assign index   = pins.idx;

  // R7: nothing moves on an edge without a strobe
  a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable({phase_a, phase_b, index, dir_up}));
  // R7: quadrature is Gray coded, one phase toggles at a time
  a_r7_one_phase: assert property (@(posedge clk) disable iff (rst)
    $countones({phase_a, phase_b} ^ $past({phase_a, phase_b})) <= 1);
  // R1: reset leaves the zero-angle pattern
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (phase_a && !phase_b && index && dir_up));
endmodule

// File: tb/qenc_emulator_bench.sv
module qenc_emulator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ANG_W      = 12;
  localparam int UPD_DIV    = 2;
  localparam int REV        = 1 << ANG_W;

  typedef struct {
    logic a, b, idx, dir;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ANG_W-1:0] angle = '0;
  logic phase_a, phase_b, index, dir_up;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  exp_t q[$];

  logic [ANG_W-1:0] m_prev = '0;
  logic             m_dir  = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  qenc_emulator #(.ANG_W(ANG_W), .UPD_DIV(UPD_DIV)) u_qenc_emulator (
    .clk(clk), .rst(rst), .angle_i(angle),
    .phase_a(phase_a), .phase_b(phase_b), .index(index), .dir_up(dir_up)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [ANG_W-1:0] ang, input string req);
    exp_t e;
    e.a   = ~ang[1];
    e.b   = ang[1] ^ ang[0];
    e.idx = (ang == '0);
    e.dir = m_dir;
    e.req = req;
    return e;
  endfunction

  // Scoreboard monitor: compare queued expectations away from the edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, phase_a, e.a, "phase_a");
        check(e.req, phase_b, e.b, "phase_b");
        check(e.req, index, e.idx, "index");
        check(e.req, dir_up, e.dir, "dir_up");
      end
    end
  end

  // Driver: present an angle right before a strobe edge, then queue the result
  task automatic step(input logic [ANG_W-1:0] ang, input string req);
    @(negedge clk);
    while ((cyc % UPD_DIV) != UPD_DIV - 1) @(negedge clk);
    angle = ang;
    @(posedge clk);
    if (ang == m_prev + 1'b1)      m_dir = 1'b1;
    else if (ang == m_prev - 1'b1) m_dir = 1'b0;
    m_prev = ang;
    q.push_back(model(ang, req));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    angle = '0;
    repeat (3) @(negedge clk);
    m_prev = '0;
    m_dir  = 1'b1;
    check("R1", phase_a, 1'b1, "phase_a in reset");
    check("R1", phase_b, 1'b0, "phase_b in reset");
    check("R1", index, 1'b1, "index in reset");
    check("R1", dir_up, 1'b1, "dir_up in reset");
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int rises;
    logic last_a;
    do_reset();

    // R3 R5: count up through several quadrature cycles
    for (int i = 1; i <= 9; i++) step(ANG_W'(i), "R3");
    // R5: reverse, pass down through zero into the top of the range
    for (int i = 8; i >= 0; i--) step(ANG_W'(i), "R5");
    step(ANG_W'(REV - 1), "R5");
    step(ANG_W'(REV - 2), "R5");
    // R4 R5: climb back through the wrap to hit the marker
    step(ANG_W'(REV - 1), "R4");
    step('0, "R4");
    step(ANG_W'(1), "R4");
    // R6: hold still, direction stays up
    repeat (3) step(ANG_W'(1), "R6");
    step('0, "R6");
    repeat (3) step('0, "R6");

    // R2: a short far jump between strobes is never sampled
    @(negedge clk);
    while ((cyc % UPD_DIV) != 0) @(negedge clk);
    angle = ANG_W'(REV / 2 + 3);
    @(negedge clk);
    angle = m_prev;
    repeat (UPD_DIV + 1) @(negedge clk);
    check("R2", phase_a, 1'b1, "phase_a after glitch");
    check("R2", phase_b, 1'b0, "phase_b after glitch");
    check("R2", index, 1'b1, "index after glitch");
    check("R2", dir_up, 1'b0, "dir_up after glitch");

    // R3: one full upward revolution gives 1024 A rising edges
    rises = 0;
    last_a = phase_a;
    for (int i = 1; i <= REV; i++) begin
      step(ANG_W'(i), "R3");
      @(negedge clk);
      if (phase_a && !last_a) rises++;
      last_a = phase_a;
    end
    checks++;
    if (rises != REV / 4) begin
      failures++;
      $display("FAIL R3 A rises actual=%0d expected=%0d", rises, REV / 4);
    end

    // R7: outputs settle only on the strobe edge
    step(ANG_W'(1), "R7");
    @(negedge clk);
    while ((cyc % UPD_DIV) != UPD_DIV - 1) @(negedge clk);
    angle = ANG_W'(2);
    check("R7", phase_b, 1'b1, "phase_b before strobe edge");
    @(negedge clk);
    check("R7", phase_b, 1'b1, "phase_b after strobe edge");
    check("R7", phase_a, 1'b0, "phase_a after strobe edge");
    m_prev = ANG_W'(2);

    // R1: reset in mid run from a downward state
    step(ANG_W'(1), "R5");
    repeat (2) @(negedge clk);
    do_reset();
    step('0, "R1");

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule